// File: doc/BRIEF.md
# Manchester II serial encoder with sync prefix

This block turns a serial NRZ bit stream into Manchester II line code on a complementary pair of outputs. It runs from an internal clock at an integer multiple of twice the bit rate. It gives the data source a 1X encoder clock. The source must hold each NRZ bit valid where that clock falls. A clear-to-send input gates the whole encoder. While it is high, the line rests with both outputs high and the encoder clock low.

There are two modes. In converter mode, a falling edge on clear-to-send starts a transmission. The transmission opens with a three-bit-time command sync and is followed by data bits with no gap. In repeater mode, clear-to-send going low starts data encoding directly, without any sync. Clear-to-send returning high ends a transmission at once in either mode.

Top module: `manchester_tx`

## Requirements
- R1: While `cts` is 1, `bip_one` and `bip_zero` are both 1 and `enc_clk` is 0, from the same clock cycle that `cts` rises.
- R2: While `rst_n` is 0, and after release until a transmission starts, both bipolar outputs are 1 and `enc_clk` is 0.
- R3: With `rep_mode` = 0, a 1-to-0 change of `cts` seen after reset starts a command sync. The sync begins one clock after the first edge at which `cts` is sampled low. On `bip_one` it is 3 half-bits at 1 and then 3 half-bits at 0. Each half-bit lasts HALF_CYC clocks.
- R4: Data bits follow the sync directly with no gap. On `bip_one`, a 1 is sent as 1 then 0, and a 0 is sent as 0 then 1, one half-bit each.
- R5: The value of `nrz_in` at the clock edge where `enc_clk` goes from 1 to 0 is the bit sent in the next bit time. The fall in the last sync bit time supplies the first data bit.
- R6: While transmitting, `enc_clk` is 1 in the first half and 0 in the second half of every bit time, sync bit times included.
- R7: While transmitting, `bip_zero` is the complement of `bip_one`.
- R8: With `rep_mode` = 1, `cts` being low while idle starts data bits directly, with no sync. The first bit is `nrz_in` at the starting edge.
- R9: With `rep_mode` = 0, `cts` held low since reset without a falling edge leaves the outputs idle (both 1, `enc_clk` 0).
- R10: In converter mode, raising and then lowering `cts` again starts a fresh command sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, 2*HALF_CYC times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_mode | input | 1 | 0 = converter mode, 1 = repeater mode |
| cts | input | 1 | Clear to send; high disables the encoder |
| nrz_in | input | 1 | Serial NRZ data, sampled at the fall of enc_clk |
| enc_clk | output | 1 | 1X encoder clock |
| bip_one | output | 1 | Manchester output, true polarity |
| bip_zero | output | 1 | Manchester output, complement polarity |

## Verification
Some properties are checked on every cycle: the idle levels while clear-to-send is high, the complementary pair whenever the encoder clock is high, the legal range of the half-bit index in sync and data phases, and that a sync can only be entered in converter mode. Other behaviour can only be shown by the bench's half-bit decoding of complete transmissions. That covers the exact sync shape and its start cycle, the per-bit Manchester polarity, the fall of the encoder clock as the moment NRZ data is taken, the sync-free start in repeater mode, and the absence of a start without a clear-to-send falling edge.

// File: rtl/man_enc_pkg.sv
package man_enc_pkg;
   // half-bits at each level in the command sync
   localparam int SYNC_HALVES = 3;
   localparam int SYNC_TOTAL  = 2 * SYNC_HALVES;
   localparam int IDX_W       = $clog2(SYNC_TOTAL);
endpackage

// File: rtl/man_enc_timer.sv
module man_enc_timer #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic half_end
);
   localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   if (HALF_CYC < 1) begin : g_bad_cfg
      $error("HALF_CYC must be at least 1");
   end

   if (HALF_CYC == 1) begin : g_direct
      assign half_end = ~clear;
   end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);
      logic [CNT_W-1:0] sub_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) sub_q <= '0;
         else if (sub_q == LAST) sub_q <= '0;
         else sub_q <= sub_q + 1'b1;
      end
      assign half_end = (sub_q == LAST) && !clear;

      p_sub_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
         sub_q <= LAST);
   end
endmodule

// File: rtl/man_enc_seq.sv
module man_enc_seq
   import man_enc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rep_mode,
   input  logic             cts,
   input  logic             nrz_in,
   input  logic             half_end,
   output logic             active,
   output logic             in_sync,
   output logic [IDX_W-1:0] half_idx,
   output logic             cur_bit
);
   localparam logic [IDX_W-1:0] SYNC_LAST = IDX_W'(SYNC_TOTAL - 1);
   localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(1);

   logic cts_q;
   logic nxt_bit;
   logic last_half;

   assign last_half = in_sync ? (half_idx == SYNC_LAST) : (half_idx == DATA_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cts_q    <= 1'b0;
         active   <= 1'b0;
         in_sync  <= 1'b0;
         half_idx <= '0;
         cur_bit  <= 1'b0;
         nxt_bit  <= 1'b0;
      end else begin
         cts_q <= cts;
         if (cts) begin
            active <= 1'b0;
         end else if (!active) begin
            if (rep_mode) begin
               active   <= 1'b1;
               in_sync  <= 1'b0;
               half_idx <= '0;
               cur_bit  <= nrz_in;
            end else if (cts_q) begin
               active   <= 1'b1;
               in_sync  <= 1'b1;
               half_idx <= '0;
            end
         end else if (half_end) begin
            if (!half_idx[0]) nxt_bit <= nrz_in;
            if (last_half) begin
               half_idx <= '0;
               in_sync  <= 1'b0;
               cur_bit  <= nxt_bit;
            end else begin
               half_idx <= half_idx + 1'b1;
            end
         end
      end
   end

   p_sync_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync |-> (half_idx <= SYNC_LAST));
   p_data_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !in_sync) |-> (half_idx <= DATA_LAST));
   p_sync_conv_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> !$past(rep_mode));
endmodule

// File: rtl/man_enc_out.sv
module man_enc_out
   import man_enc_pkg::*;
(
   input  logic             cts,
   input  logic             active,
   input  logic             in_sync,
   input  logic [IDX_W-1:0] half_idx,
   input  logic             cur_bit,
   output logic             enc_clk,
   output logic             bip_one,
   output logic             bip_zero
);
   logic tx_on;
   logic line_bit;

   assign tx_on = active & ~cts;

   always_comb begin
      if (in_sync) line_bit = (half_idx < IDX_W'(SYNC_HALVES));
      else         line_bit = half_idx[0] ? ~cur_bit : cur_bit;
   end

   assign bip_one  = tx_on ? line_bit  : 1'b1;
   assign bip_zero = tx_on ? ~line_bit : 1'b1;
   assign enc_clk  = tx_on & ~half_idx[0];
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
   import man_enc_pkg::*;
#(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rep_mode,
   input  logic cts,
   input  logic nrz_in,
   output logic enc_clk,
   output logic bip_one,
   output logic bip_zero
);
   logic             half_end;
   logic             active;
   logic             in_sync;
   logic [IDX_W-1:0] half_idx;
   logic             cur_bit;

   man_enc_timer #(.HALF_CYC(HALF_CYC)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (~active),
      .half_end (half_end)
   );

   man_enc_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rep_mode (rep_mode),
      .cts      (cts),
      .nrz_in   (nrz_in),
      .half_end (half_end),
      .active   (active),
      .in_sync  (in_sync),
      .half_idx (half_idx),
      .cur_bit  (cur_bit)
   );

   man_enc_out i_out (
      .cts      (cts),
      .active   (active),
      .in_sync  (in_sync),
      .half_idx (half_idx),
      .cur_bit  (cur_bit),
      .enc_clk  (enc_clk),
      .bip_one  (bip_one),
      .bip_zero (bip_zero)
   );

   p_idle_cts_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cts |-> (bip_one && bip_zero && !enc_clk));
   p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      enc_clk |-> (bip_one != bip_zero));
endmodule

// File: tb/test_manchester_tx.sv
`timescale 1ns/1ps
module test_manchester_tx;
   localparam int H = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rep_mode = 1'b0;
   logic cts = 1'b0;
   logic nrz_in = 1'b0;
   logic enc_clk, bip_one, bip_zero;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   manchester_tx #(.HALF_CYC(H)) i_manchester_tx (
      .clk(clk), .rst_n(rst_n), .rep_mode(rep_mode), .cts(cts),
      .nrz_in(nrz_in), .enc_clk(enc_clk), .bip_one(bip_one), .bip_zero(bip_zero)
   );

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk({bip_one, bip_zero, enc_clk}, 3'b110, req);
   endtask

   // one half-bit: checks every clock, drives nrz at its first negedge
   task automatic half_step(input logic e_one, input logic e_clk,
                            input logic nxt, input string req);
      for (int c = 0; c < H; c++) begin
         @(negedge clk);
         if (c == 0) nrz_in = nxt;
         chk(bip_one, e_one, req);
         chk(bip_zero, !e_one, "R7");
         chk(enc_clk, e_clk, "R6");
         @(posedge clk);
      end
   endtask

   task automatic send_bits(input logic [3:0] b, input int n);
      for (int k = 0; k < n; k++) begin
         half_step(b[k], 1'b1, (k + 1 < n) ? b[k+1] : 1'b0, "R4");
         half_step(!b[k], 1'b0, 1'b0, "R5");
      end
   endtask

   task automatic stop_tx;
      @(negedge clk);
      cts = 1'b1;
      #0.5;
      chk_idle("R1");
      repeat (2) @(negedge clk);
      chk_idle("R1");
   endtask

   task automatic conv_tx(input logic [3:0] b);
      @(negedge clk);
      rep_mode = 1'b0;
      cts = 1'b1;
      repeat (2) @(negedge clk);
      cts = 1'b0;
      @(posedge clk);
      for (int h = 0; h < 6; h++)
         half_step(h < 3, (h % 2) == 0, (h == 4) ? b[0] : 1'b0, "R3");
      send_bits(b, 4);
      stop_tx();
   endtask

   task automatic rep_tx(input logic [3:0] b);
      @(negedge clk);
      rep_mode = 1'b1;
      cts = 1'b1;
      repeat (2) @(negedge clk);
      nrz_in = b[0];
      cts = 1'b0;
      @(posedge clk);
      for (int k = 0; k < 3; k++) begin
         half_step(b[k], 1'b1, (k < 2) ? b[k+1] : 1'b0, "R8");
         half_step(!b[k], 1'b0, 1'b0, "R8");
      end
      stop_tx();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R2");
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk_idle("R9");
      end
      for (int p = 0; p < 16; p++) conv_tx(4'(p));   // R10: each one restarts
      for (int p = 0; p < 8; p++) rep_tx(4'(p));
      conv_tx(4'b1010);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule